// File: doc/BRIEF.md
# Single-Wire ROM Identifier Slave

This block is the slave side of a single-wire, open-drain, bit-serial bus. It carries a fixed 64-bit identity made of a one-byte family code, a 48-bit serial number and a check byte. The check byte is computed from the other 56 bits when the block is elaborated. The line is shared with a master and with other slaves. The block sees it through a sampled input, and it can only pull it low, through an open-drain enable. All of its timing comes from a one-microsecond strobe.

A transaction begins when the master holds the line low for a long time. The slave answers with a presence pulse and then takes in an 8-bit command, least significant bit first, one bit per write slot. There are two read-identity opcodes, and either one streams all 64 identity bits out in read slots. The search opcode runs the bitwise search: for each bit the slave sends the bit, then its complement, and then takes the master's chosen direction. It drops out of the pass as soon as that direction differs from its own bit. The match and skip opcodes make the slave go quiet until the next reset, and so does any other opcode.

Top module: `owire_id_slave`

## Requirements
- R1: After `rst_n` is released, `pull_low` stays 0 until the bus has carried a reset pulse.
- R2: When the line has been low for at least RESET_US (480) µs and then rises, the slave waits 15 to 60 µs (PD_WAIT_US, default 30) and then holds `pull_low` for 60 to 240 µs (PD_LEN_US, default 120).
- R3: In idle, a low that is shorter than RESET_US (for example 300 µs) produces no presence pulse.
- R4: Each command bit is sampled SAMPLE_US (30) µs after the falling edge that opens its slot. A low line reads as 0 and a high line as 1. The first bit received is bit 0 of the command.
- R5: Command 33h starts a readout in which read slot i carries identity bit i, for i = 0 to 63. Bits 7:0 hold the family code 01h, bits 55:8 hold the serial number and bits 63:56 hold the check byte.
- R6: Command 0Fh starts the same 64-bit readout as 33h.
- R7: The check byte is the CRC of identity bits 0 to 55, taken bit 0 first, with polynomial x^8+x^5+x^4+1 in reflected form, an initial value of 0 and no final inversion.
- R8: A read slot that carries a 0 holds the line low from the falling edge for HOLD_US (15) µs and then releases it. A slot that carries a 1 leaves the line released.
- R9: After command 55h or CCh the slave pulls the line in no slot until the next reset pulse.
- R10: After any other unsupported command the slave returns to idle and pulls the line in no slot until the next reset pulse.
- R11: After command F0h, each identity bit i (0 to 63) takes three slots: a read slot with bit i, a read slot with its complement, and a write slot with the master's direction. When the direction matches, the search moves on to bit i+1, and the slave is idle after bit 63.
- R12: During the search, a direction that differs from the slave's own bit ends the slave's part in that pass. It pulls the line in no later slot until the next reset.
- R13: A reset pulse in the middle of a readout ends the readout. A presence pulse follows, and a new command is then accepted from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| bus_in | input | 1 | Sampled level of the shared line (1 = high) |
| pull_low | output | 1 | Open-drain enable: 1 pulls the line low |

## Verification
Some rules hold on every cycle, and the embedded properties check those. The line is pulled only inside a read slot or a presence pulse. A write slot never pulls. A read slot releases the line once its hold time ends. No state that must stay silent ever pulls. A completed reset pulse always starts the presence wait. A mismatched search direction always sends the sequencer to idle. Other behaviour can only be shown by the bench's bus-level scenarios: the exact bit order of a readout, the check byte value, the two read opcodes, silence after match, skip and unknown opcodes, a full 64-bit search pass, and a reset in the middle of a transaction.

// File: rtl/owid_pkg.sv
package owid_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PD_WAIT,
      ST_PD_LOW,
      ST_CMD,
      ST_READ,
      ST_S_BIT,
      ST_S_CMP,
      ST_S_DIR,
      ST_QUIET
   } owid_state_e;

   localparam int ID_W  = 64;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] OP_READ_A = 8'h33;
   localparam logic [CMD_W-1:0] OP_READ_B = 8'h0F;
   localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
   localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
   localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;

   // Reflected CRC-8, polynomial x^8+x^5+x^4+1, bit 0 first.
   function automatic logic [7:0] id_crc8(input logic [ID_W-9:0] payload);
      logic [7:0] acc;
      logic       mix;
      acc = 8'h00;
      for (int k = 0; k < ID_W - 8; k++) begin
         mix = acc[0] ^ payload[k];
         acc = acc >> 1;
         if (mix) acc = acc ^ 8'h8C;
      end
      return acc;
   endfunction

endpackage

// File: rtl/owid_line_sense.sv
module owid_line_sense #(
   parameter int SYNC_STAGES = 2,
   parameter int RESET_US    = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic bus_in,
   output logic line_o,
   output logic fall_o,
   output logic rst_det_o
);
   localparam int LW = $clog2(RESET_US + 1);
   localparam logic [LW-1:0] LOW_LIM = LW'(RESET_US);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [LW-1:0]          low_us_q;
   logic                   line_now;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= bus_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], bus_in};
      end
   end

   assign line_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b1;
         low_us_q <= '0;
      end else begin
         prev_q <= line_now;
         if (line_now)                           low_us_q <= '0;
         else if (tick_us && low_us_q != LOW_LIM) low_us_q <= low_us_q + 1'b1;
      end
   end

   assign line_o    = line_now;
   assign fall_o    = prev_q & ~line_now;
   assign rst_det_o = ~prev_q & line_now & (low_us_q == LOW_LIM);

endmodule

// File: rtl/owid_slot_timer.sv
module owid_slot_timer #(
   parameter int SAMPLE_US = 30,
   parameter int HOLD_US   = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic abort_i,
   input  logic start_i,
   input  logic is_write_i,
   input  logic send_bit_i,
   input  logic line_i,
   output logic busy_o,
   output logic wr_valid_o,
   output logic wr_bit_o,
   output logic rd_done_o,
   output logic pull_o
);
   localparam int END_US = (SAMPLE_US > HOLD_US) ? SAMPLE_US : HOLD_US;
   localparam int CW     = $clog2(END_US + 1);
   localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_US - 1);
   localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_US - 1);

   if (HOLD_US < 1 || SAMPLE_US <= HOLD_US) begin : g_bad_timing
      $error("need 1 <= HOLD_US < SAMPLE_US");
   end

   logic          busy_q, wr_q, pull_q;
   logic [CW-1:0] us_q;
   logic          wr_end, rd_end;

   assign wr_end = busy_q &  wr_q && tick_us && us_q == SAMPLE_LAST;
   assign rd_end = busy_q & ~wr_q && tick_us && us_q == HOLD_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         pull_q <= 1'b0;
         us_q   <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         pull_q <= 1'b0;
         us_q   <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            wr_q   <= is_write_i;
            us_q   <= '0;
            pull_q <= ~is_write_i & ~send_bit_i;
         end
      end else if (wr_end || rd_end) begin
         busy_q <= 1'b0;
         pull_q <= 1'b0;
      end else if (tick_us) begin
         us_q <= us_q + 1'b1;
      end
   end

   assign busy_o     = busy_q;
   assign wr_valid_o = wr_end;
   assign wr_bit_o   = line_i;
   assign rd_done_o  = rd_end;
   assign pull_o     = pull_q;

   AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      pull_q |-> busy_q && !wr_q);                                   // R8
   AST_WRITE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_q) |-> !pull_q);                                 // R4
   AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_end |=> !pull_q);                                           // R8

endmodule

// File: rtl/owid_ctrl.sv
module owid_ctrl
   import owid_pkg::*;
#(
   parameter logic [ID_W-1:0] ID_VAL     = '0,
   parameter int              PD_WAIT_US = 30,
   parameter int              PD_LEN_US  = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic rst_det_i,
   input  logic fall_i,
   input  logic slot_busy_i,
   input  logic wr_valid_i,
   input  logic wr_bit_i,
   input  logic rd_done_i,
   input  logic slot_pull_i,
   output logic slot_start_o,
   output logic slot_write_o,
   output logic slot_send_o,
   output logic pull_low_o
);
   localparam int PD_MAX = (PD_WAIT_US > PD_LEN_US) ? PD_WAIT_US : PD_LEN_US;
   localparam int PW     = $clog2(PD_MAX + 1);
   localparam int IW     = $clog2(ID_W);
   localparam logic [PW-1:0] WAIT_LAST = PW'(PD_WAIT_US - 1);
   localparam logic [PW-1:0] LEN_LAST  = PW'(PD_LEN_US - 1);
   localparam logic [IW-1:0] ID_LAST   = IW'(ID_W - 1);
   localparam logic [IW-1:0] CMD_LAST  = IW'(CMD_W - 1);

   owid_state_e       state_q, cmd_state;
   logic [PW-1:0]     pd_us_q;
   logic              pd_q;
   logic [IW-1:0]     idx_q;
   logic [CMD_W-1:0]  cmd_q, cmd_next;
   logic              id_bit, slot_state;

   assign id_bit   = ID_VAL[idx_q];
   assign cmd_next = {wr_bit_i, cmd_q[CMD_W-1:1]};

   always_comb begin
      unique case (cmd_next)
         OP_READ_A, OP_READ_B: cmd_state = ST_READ;
         OP_SEARCH:            cmd_state = ST_S_BIT;
         OP_MATCH, OP_SKIP:    cmd_state = ST_QUIET;
         default:              cmd_state = ST_IDLE;
      endcase
   end

   assign slot_state   = state_q inside {ST_CMD, ST_READ, ST_S_BIT, ST_S_CMP, ST_S_DIR};
   assign slot_start_o = fall_i & ~slot_busy_i & slot_state;
   assign slot_write_o = (state_q == ST_CMD) || (state_q == ST_S_DIR);
   assign slot_send_o  = (state_q == ST_S_CMP) ? ~id_bit : id_bit;
   assign pull_low_o   = pd_q | slot_pull_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pd_us_q <= '0;
         pd_q    <= 1'b0;
         idx_q   <= '0;
         cmd_q   <= '0;
      end else if (rst_det_i) begin
         state_q <= ST_PD_WAIT;
         pd_us_q <= '0;
         pd_q    <= 1'b0;
         idx_q   <= '0;
         cmd_q   <= '0;
      end else begin
         unique case (state_q)
            ST_PD_WAIT: if (tick_us) begin
               if (pd_us_q == WAIT_LAST) begin
                  state_q <= ST_PD_LOW;
                  pd_us_q <= '0;
                  pd_q    <= 1'b1;
               end else pd_us_q <= pd_us_q + 1'b1;
            end
            ST_PD_LOW: if (tick_us) begin
               if (pd_us_q == LEN_LAST) begin
                  state_q <= ST_CMD;
                  pd_us_q <= '0;
                  pd_q    <= 1'b0;
                  idx_q   <= '0;
               end else pd_us_q <= pd_us_q + 1'b1;
            end
            ST_CMD: if (wr_valid_i) begin
               cmd_q <= cmd_next;
               if (idx_q == CMD_LAST) begin
                  idx_q   <= '0;
                  state_q <= cmd_state;
               end else idx_q <= idx_q + 1'b1;
            end
            ST_READ: if (rd_done_i) begin
               if (idx_q == ID_LAST) state_q <= ST_IDLE;
               else                  idx_q   <= idx_q + 1'b1;
            end
            ST_S_BIT: if (rd_done_i) state_q <= ST_S_CMP;
            ST_S_CMP: if (rd_done_i) state_q <= ST_S_DIR;
            ST_S_DIR: if (wr_valid_i) begin
               if (wr_bit_i != id_bit || idx_q == ID_LAST) state_q <= ST_IDLE;
               else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_S_BIT;
               end
            end
            default: ;
         endcase
      end
   end

   AST_RESET_TO_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_det_i |=> state_q == ST_PD_WAIT);                          // R2
   AST_SILENT_STATES: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {ST_IDLE, ST_QUIET, ST_CMD, ST_PD_WAIT, ST_S_DIR}) |-> !pull_low_o); // R9
   AST_SEARCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S_DIR && wr_valid_i && !rst_det_i && wr_bit_i != id_bit)
      |=> state_q == ST_IDLE);                                       // R12

endmodule

// File: rtl/owire_id_slave.sv
module owire_id_slave
   import owid_pkg::*;
#(
   parameter logic [7:0]  FAMILY_CODE = 8'h01,
   parameter logic [47:0] SERIAL_NUM  = 48'h00A1_B2C3_D4E5,
   parameter int          SYNC_STAGES = 2,
   parameter int          RESET_US    = 480,
   parameter int          PD_WAIT_US  = 30,
   parameter int          PD_LEN_US   = 120,
   parameter int          SAMPLE_US   = 30,
   parameter int          HOLD_US     = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic bus_in,
   output logic pull_low
);
   localparam logic [ID_W-9:0] PAYLOAD = {SERIAL_NUM, FAMILY_CODE};
   localparam logic [ID_W-1:0] ID_VAL  = {id_crc8(PAYLOAD), PAYLOAD};

   if (PD_WAIT_US < 15 || PD_WAIT_US > 60) begin : g_bad_wait
      $error("PD_WAIT_US outside 15..60");
   end
   if (PD_LEN_US < 60 || PD_LEN_US > 240) begin : g_bad_len
      $error("PD_LEN_US outside 60..240");
   end
   if (RESET_US <= PD_LEN_US) begin : g_bad_reset
      $error("RESET_US must exceed the presence length");
   end

   logic line, fall, rst_det;
   logic slot_busy, wr_valid, wr_bit, rd_done, slot_pull;
   logic slot_start, slot_write, slot_send;

   owid_line_sense #(.SYNC_STAGES(SYNC_STAGES), .RESET_US(RESET_US)) u_sense (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_in(bus_in),
      .line_o(line), .fall_o(fall), .rst_det_o(rst_det)
   );

   owid_slot_timer #(.SAMPLE_US(SAMPLE_US), .HOLD_US(HOLD_US)) u_slot (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .abort_i(rst_det),
      .start_i(slot_start), .is_write_i(slot_write), .send_bit_i(slot_send),
      .line_i(line), .busy_o(slot_busy), .wr_valid_o(wr_valid),
      .wr_bit_o(wr_bit), .rd_done_o(rd_done), .pull_o(slot_pull)
   );

   owid_ctrl #(.ID_VAL(ID_VAL), .PD_WAIT_US(PD_WAIT_US), .PD_LEN_US(PD_LEN_US)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .rst_det_i(rst_det),
      .fall_i(fall), .slot_busy_i(slot_busy), .wr_valid_i(wr_valid),
      .wr_bit_i(wr_bit), .rd_done_i(rd_done), .slot_pull_i(slot_pull),
      .slot_start_o(slot_start), .slot_write_o(slot_write),
      .slot_send_o(slot_send), .pull_low_o(pull_low)
   );

endmodule

// File: tb/owire_id_slave_tb.sv
`timescale 1ns/1ps
module owire_id_slave_tb;
   localparam int CLK_NS     = 10;
   localparam int CLK_PER_US = 2;
   localparam logic [7:0]  FAM = 8'h01;
   localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic m_low = 1'b0;
   logic pull_low;
   logic bus_in;
   logic [3:0] tdiv = 4'd0;

   assign bus_in = ~(m_low | pull_low);

   always #(CLK_NS/2) clk = ~clk;

   always @(posedge clk) begin
      tdiv    <= (tdiv == 4'(CLK_PER_US - 1)) ? 4'd0 : tdiv + 4'd1;
      tick_us <= (tdiv == 4'(CLK_PER_US - 1));
   end

   owire_id_slave u_dut (.clk(clk), .rst_n(rst_n), .tick_us(tick_us),
                         .bus_in(bus_in), .pull_low(pull_low));

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   function automatic logic [7:0] ref_crc(input logic [55:0] d);
      logic [7:0] c;
      logic fb;
      c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         fb = c[0] ^ d[i];
         c = {fb, c[7], c[6], c[5], c[4] ^ fb, c[3] ^ fb, c[2], c[1]};
      end
      return c;
   endfunction

   localparam logic [63:0] EXP_ID = {ref_crc({SER, FAM}), SER, FAM};

   task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // scoreboard
   bit    exp_q[$];
   string tag_q[$];
   bit    got_q[$];
   event  got_ev;

   initial forever begin
      @(got_ev);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
         bit g, e;
         string t;
         g = got_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(g == e, t, 64'(g), 64'(e));
      end
   end

   task automatic wait_us(input int n);
      repeat (n * CLK_PER_US) @(negedge clk);
   endtask

   task automatic bus_low(input int low_us, input bit expect_pd, input string tag);
      int t1, t2;
      m_low = 1'b1;
      wait_us(low_us);
      m_low = 1'b0;
      t1 = -1;
      t2 = -1;
      for (int t = 1; t <= 300; t++) begin
         wait_us(1);
         if (!bus_in && t1 < 0) t1 = t;
         if (bus_in && t1 >= 0 && t2 < 0) t2 = t;
      end
      if (expect_pd) begin
         check(t1 >= 15 && t1 <= 60, {tag, " presence delay"}, 64'(t1), 64'd30);
         check(t2 - t1 >= 60 && t2 - t1 <= 240, {tag, " presence width"}, 64'(t2 - t1), 64'd120);
      end else begin
         check(t1 < 0, {tag, " no presence"}, 64'(t1), 64'hFFFF_FFFF_FFFF_FFFF);
      end
      wait_us(200);
   endtask

   task automatic write_bit(input bit b);
      m_low = 1'b1;
      wait_us(b ? 2 : 65);
      m_low = 1'b0;
      wait_us(b ? 68 : 5);
   endtask

   task automatic write_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) write_bit(v[i]);
   endtask

   task automatic read_slot(input bit e, input string tag, output bit got);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      m_low = 1'b1;
      wait_us(2);
      m_low = 1'b0;
      wait_us(10);
      got = bus_in;
      got_q.push_back(got);
      ->got_ev;
      wait_us(13);
      check(bus_in == 1'b1, "R8 release after hold", 64'(bus_in), 64'd1);
      wait_us(45);
   endtask

   task automatic quiet_after(input logic [7:0] op, input string tag);
      bit g;
      bus_low(500, 1'b1, tag);
      write_byte(op);
      for (int i = 0; i < 8; i++) read_slot(1'b1, tag, g);
   endtask

   initial begin
      logic [63:0] word;
      bit g;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: no pull after reset release
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (pull_low) begin
            check(1'b0, "R1 idle after rst_n", 64'(pull_low), 64'd0);
            break;
         end
      end
      check(pull_low == 1'b0, "R1 idle after rst_n", 64'(pull_low), 64'd0);

      // R3: short low ignored
      bus_low(300, 1'b0, "R3");

      // R2 / R4 / R5 / R7: read with 33h
      bus_low(500, 1'b1, "R2");
      write_byte(8'h33);
      word = '0;
      for (int i = 0; i < 64; i++) begin
         read_slot(EXP_ID[i], (i == 0) ? "R4 R5 first bit" : "R5 readout", g);
         word[i] = g;
      end
      check(word[7:0] == 8'h01, "R5 family byte", 64'(word[7:0]), 64'h01);
      check(word == EXP_ID, "R5 identity word", word, EXP_ID);
      check(word[63:56] == ref_crc(word[55:0]), "R7 check byte", 64'(word[63:56]), 64'(ref_crc(word[55:0])));

      // R13: reset during readout, then 0Fh (R6)
      bus_low(500, 1'b1, "R13 setup");
      write_byte(8'h33);
      for (int i = 0; i < 5; i++) read_slot(EXP_ID[i], "R13 partial", g);
      bus_low(500, 1'b1, "R13");
      write_byte(8'h0F);
      for (int i = 0; i < 64; i++) read_slot(EXP_ID[i], "R6 readout", g);

      // R9 / R10: silent commands
      quiet_after(8'h55, "R9 match");
      quiet_after(8'hCC, "R9 skip");
      quiet_after(8'h99, "R10 unknown");

      // R11: full search pass
      bus_low(500, 1'b1, "R11 setup");
      write_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
         read_slot(EXP_ID[i], "R11 bit", g);
         read_slot(~EXP_ID[i], "R11 complement", g);
         write_bit(EXP_ID[i]);
      end
      read_slot(1'b1, "R11 idle after pass", g);

      // R12: mismatch at bit 3
      bus_low(500, 1'b1, "R12 setup");
      write_byte(8'hF0);
      for (int i = 0; i < 4; i++) begin
         read_slot(EXP_ID[i], "R12 bit", g);
         read_slot(~EXP_ID[i], "R12 complement", g);
         write_bit((i == 3) ? ~EXP_ID[i] : EXP_ID[i]);
      end
      for (int i = 0; i < 6; i++) read_slot(1'b1, "R12 dropped", g);

      wait_us(5);
      check(exp_q.size() == 0, "scoreboard drained R5", 64'(exp_q.size()), 64'd0);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule